// File: doc/BRIEF.md
# Processor Status and Flag Unit

This unit keeps the eight-bit processor status byte and a separate emulation bit for a processor core whose accumulator and index datapaths switch between 8 and 16 bits. Each clock cycle it takes at most one command. A command can set or clear a single flag, clear or set flags under a mask byte, swap carry with the emulation bit, or replace the whole byte with a value pulled from the stack. Two other commands fold a datapath result into the flags: a load result updates negative and zero, and a compare updates negative, zero and carry.

The width used for a load or a compare is not given on the port. The unit reads it from the size bits it holds. A select input names either the accumulator-size bit or the index-size bit, and the negative flag then comes from bit 7 or bit 15 of the value. While the emulation bit is 1 both size controls read as 8-bit. In that mode, status bit 4 is a plain break flag with no effect on the index width.

The accumulator-size and index-size controls are registered and decoded for the datapath. The unit also gives a one-cycle strobe that tells the index registers to zero their high bytes when the index width narrows. Arithmetic and interrupt sequencing sit outside this unit.

Top module: `psr_unit`

## Requirements
- R1: After a synchronous reset, status_o is 0x30, emu_o is 1, acc8_o and idx8_o are 1, and idx_hi_clr_o is 0.
- R2: Status bit positions are C=0, Z=1, I=2, D=3, X=4, M=5, V=6, N=7. Op code 1 sets and op code 2 clears the single bit whose position is on flag_sel_i. No other bit changes. The result is visible after the next clock edge.
- R3: Op code 3 clears every status bit that is 1 in mask_i. Op code 4 sets every status bit that is 1 in mask_i. Both are subject to R5.
- R4: Op code 5 exchanges status bit 0 (carry) with emu_o.
- R5: Whenever emu_o is 1, status bit 5 is held at 1 and acc8_o and idx8_o are 1. Status bit 4 then acts as a break flag: commands can change it and it does not affect idx8_o. A swap that moves emu_o from 0 to 1 also sets bits 5 and 4.
- R6: Op code 7 updates only N and Z from value_i. The width is taken from the accumulator size (use_idx_i=0) or the index size (use_idx_i=1). At 8-bit width, N is bit 7 and Z means bits 7..0 are all zero. At 16-bit width, N is bit 15 and Z means all 16 bits are zero.
- R7: Op code 8 compares cmp_a_i with cmp_b_i at the width chosen as in R6. At 8-bit width only bits 7..0 are used. Z is set when the difference is zero, N is the difference's top bit at that width, and C is set when cmp_a_i is not below cmp_b_i (unsigned). V, I, D, M and X are kept.
- R8: Op code 6 loads mask_i into the whole status byte, subject to R5.
- R9: idx_hi_clr_o is 1 for exactly the one cycle in which idx8_o has just changed from 0 to 1. It rises on the same edge as idx8_o.
- R10: Op code 0 and the unused op codes 9 to 15 leave all state unchanged. With emu_o at 0, acc8_o equals status bit 5 and idx8_o equals status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Command code (R2 to R10) |
| flag_sel_i | input | 3 | Bit position for single-flag set or clear |
| mask_i | input | 8 | Mask for mask commands; byte for the stack-pull load |
| use_idx_i | input | 1 | Width source: 0 accumulator size, 1 index size |
| value_i | input | DATA_W | Load result for the N/Z update |
| cmp_a_i | input | DATA_W | Compare register operand |
| cmp_b_i | input | DATA_W | Compare memory operand |
| status_o | output | 8 | Processor status byte |
| emu_o | output | 1 | Emulation bit |
| acc8_o | output | 1 | Accumulator is 8-bit |
| idx8_o | output | 1 | Index registers are 8-bit |
| idx_hi_clr_o | output | 1 | Strobe to zero the index registers' high bytes |

## Verification
A wrong bit in the held status byte shows on status_o at the very next edge. It also spreads: a wrong size bit changes the width of every later load and compare, so N and Z come from the wrong bit position on the next such command. A fault in emulation forcing or in the size decode shows on acc8_o and idx8_o in the same cycle as the status change. A missed or repeated high-byte strobe shows as idx_hi_clr_o out of step with the rising edge of idx8_o. The bench checks every output after every command, so any such fault appears within one command of its cause.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_Z  = 1;
  localparam int BIT_X  = 4;
  localparam int BIT_M  = 5;
  localparam int BIT_V  = 6;
  localparam int BIT_N  = 7;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h30;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_FLAG_SET = 4'd1,
    OP_FLAG_CLR = 4'd2,
    OP_MASK_CLR = 4'd3,
    OP_MASK_SET = 4'd4,
    OP_SWAP_CE  = 4'd5,
    OP_PULL     = 4'd6,
    OP_LOAD_NZ  = 4'd7,
    OP_COMPARE  = 4'd8
  } psr_op_e;
endpackage

// File: rtl/psr_nz_eval.sv
// Negative/zero of a value at the narrow or full width.
module psr_nz_eval #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic              narrow,
  output logic              neg,
  output logic              zero
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (narrow) begin
      neg  = value[HALF_W-1];
      zero = ~|value[HALF_W-1:0];
    end else begin
      neg  = value[DATA_W-1];
      zero = ~|value;
    end
  end
endmodule

// File: rtl/psr_compare.sv
// Unsigned compare at a selectable width, producing N, Z and no-borrow.
module psr_compare #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              narrow,
  output logic              neg,
  output logic              zero,
  output logic              no_borrow
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] diff;

  assign diff = lhs - rhs;
  assign no_borrow = narrow ? (lhs[HALF_W-1:0] >= rhs[HALF_W-1:0]) : (lhs >= rhs);

  psr_nz_eval #(.DATA_W(DATA_W)) diff_nz_i (
    .value (diff),
    .narrow(narrow),
    .neg   (neg),
    .zero  (zero)
  );
endmodule

// File: rtl/psr_next.sv
// Next-state network for the status byte and the emulation bit.
module psr_next
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [STAT_W-1:0] st,
  input  logic              emu,
  input  psr_op_e           op,
  input  logic [2:0]        flag_sel,
  input  logic [STAT_W-1:0] mask,
  input  logic              use_idx,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic [STAT_W-1:0] st_n,
  output logic              emu_n
);
  logic              narrow;
  logic              ld_neg, ld_zero;
  logic              cp_neg, cp_zero, cp_carry;
  logic [STAT_W-1:0] sel_hit;
  logic [STAT_W-1:0] pre;

  // Width comes from the held size bits; emulation forces 8-bit.
  assign narrow = use_idx ? (emu | st[BIT_X]) : (emu | st[BIT_M]);

  for (genvar i = 0; i < STAT_W; i++) begin : g_sel
    assign sel_hit[i] = (flag_sel == 3'(i));
  end

  psr_nz_eval #(.DATA_W(DATA_W)) load_nz_i (
    .value (value),
    .narrow(narrow),
    .neg   (ld_neg),
    .zero  (ld_zero)
  );

  psr_compare #(.DATA_W(DATA_W)) cmp_i (
    .lhs      (cmp_a),
    .rhs      (cmp_b),
    .narrow   (narrow),
    .neg      (cp_neg),
    .zero     (cp_zero),
    .no_borrow(cp_carry)
  );

  always_comb begin
    pre   = st;
    emu_n = emu;
    case (op)
      OP_FLAG_SET: pre = st | sel_hit;
      OP_FLAG_CLR: pre = st & ~sel_hit;
      OP_MASK_CLR: pre = st & ~mask;
      OP_MASK_SET: pre = st | mask;
      OP_PULL:     pre = mask;
      OP_SWAP_CE: begin
        pre[BIT_C] = emu;
        emu_n      = st[BIT_C];
        if (st[BIT_C] && !emu) begin
          pre[BIT_M] = 1'b1;
          pre[BIT_X] = 1'b1;
        end
      end
      OP_LOAD_NZ: begin
        pre[BIT_N] = ld_neg;
        pre[BIT_Z] = ld_zero;
      end
      OP_COMPARE: begin
        pre[BIT_N] = cp_neg;
        pre[BIT_Z] = cp_zero;
        pre[BIT_C] = cp_carry;
      end
      default: ;
    endcase
    st_n = pre;
    if (emu_n) st_n[BIT_M] = 1'b1;
  end
endmodule

// File: rtl/psr_unit.sv
// Processor status register with width-aware flag updates.
module psr_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [2:0]        flag_sel_i,
  input  logic [7:0]        mask_i,
  input  logic              use_idx_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] cmp_a_i,
  input  logic [DATA_W-1:0] cmp_b_i,
  output logic [7:0]        status_o,
  output logic              emu_o,
  output logic              acc8_o,
  output logic              idx8_o,
  output logic              idx_hi_clr_o
);
  logic [STAT_W-1:0] st_q, st_n;
  logic              emu_q, emu_n;
  logic              acc8_q, idx8_q, clr_q;
  logic              idx8_n;

  psr_next #(.DATA_W(DATA_W)) next_i (
    .st      (st_q),
    .emu     (emu_q),
    .op      (psr_op_e'(op_i)),
    .flag_sel(flag_sel_i),
    .mask    (mask_i),
    .use_idx (use_idx_i),
    .value   (value_i),
    .cmp_a   (cmp_a_i),
    .cmp_b   (cmp_b_i),
    .st_n    (st_n),
    .emu_n   (emu_n)
  );

  assign idx8_n = emu_n | st_n[BIT_X];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= STAT_RESET;
      emu_q  <= 1'b1;
      acc8_q <= 1'b1;
      idx8_q <= 1'b1;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      emu_q  <= emu_n;
      acc8_q <= emu_n | st_n[BIT_M];
      idx8_q <= idx8_n;
      clr_q  <= idx8_n & ~idx8_q;
    end
  end

  assign status_o     = st_q;
  assign emu_o        = emu_q;
  assign acc8_o       = acc8_q;
  assign idx8_o       = idx8_q;
  assign idx_hi_clr_o = clr_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [7:0]        mask_i,
  input logic [7:0]        status_o,
  input logic              emu_o,
  input logic              acc8_o,
  input logic              idx8_o,
  input logic              idx_hi_clr_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (status_o == 8'h30) && emu_o && acc8_o && idx8_o && !idx_hi_clr_o);

  // R5
  emu_forcing_chk: assert property (@(posedge clk) disable iff (rst)
    emu_o |-> status_o[5] && acc8_o && idx8_o);

  // R10
  native_decode_chk: assert property (@(posedge clk) disable iff (rst)
    !emu_o |-> (acc8_o == status_o[5]) && (idx8_o == status_o[4]));

  // R4
  swap_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd5) |=> (emu_o == $past(status_o[0])) && (status_o[0] == $past(emu_o)));

  // R3
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd3) |=> ((status_o & $past(mask_i) & 8'hDF) == 8'h00));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4) |=> ((status_o & $past(mask_i)) == $past(mask_i)));

  // R6
  load_keeps_vc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7) |=> (status_o[6] == $past(status_o[6])) && (status_o[0] == $past(status_o[0])));

  // R9
  strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    idx_hi_clr_o |-> idx8_o && !$past(idx8_o));

  // R9
  strobe_missing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idx8_o) |-> idx_hi_clr_o);
endmodule

bind psr_unit psr_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .op_i        (op_i),
  .mask_i      (mask_i),
  .status_o    (status_o),
  .emu_o       (emu_o),
  .acc8_o      (acc8_o),
  .idx8_o      (idx8_o),
  .idx_hi_clr_o(idx_hi_clr_o)
);

// File: tb/psr_unit_tb_top.sv
`timescale 1ns/1ps
module psr_unit_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op = 4'd0;
  logic [2:0]    fsel = 3'd0;
  logic [7:0]    mask = 8'd0;
  logic          uidx = 1'b0;
  logic [DW-1:0] val = '0;
  logic [DW-1:0] ca = '0;
  logic [DW-1:0] cb = '0;
  logic [7:0]    status;
  logic          emu, acc8, idx8, hclr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Bench-side expected state
  logic [7:0] m_st;
  logic       m_emu;
  logic       m_idx8;

  always #2 clk = ~clk;

  psr_unit #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .flag_sel_i(fsel), .mask_i(mask),
    .use_idx_i(uidx), .value_i(val), .cmp_a_i(ca), .cmp_b_i(cb),
    .status_o(status), .emu_o(emu), .acc8_o(acc8), .idx8_o(idx8),
    .idx_hi_clr_o(hclr)
  );

  task automatic check_outputs(input string tag, input logic exp_clr);
    logic e_acc8, e_idx8;
    e_acc8 = m_emu | m_st[5];
    e_idx8 = m_emu | m_st[4];
    compared++;
    if (status !== m_st || emu !== m_emu || acc8 !== e_acc8 || idx8 !== e_idx8 || hclr !== exp_clr) begin
      mismatched++;
      $display("FAIL %s: got st=%02h emu=%0b acc8=%0b idx8=%0b clr=%0b exp st=%02h emu=%0b acc8=%0b idx8=%0b clr=%0b",
               tag, status, emu, acc8, idx8, hclr, m_st, m_emu, e_acc8, e_idx8, exp_clr);
    end
  endtask

  // Drive one command, advance the model per the requirements, compare.
  task automatic step(input logic [3:0] o, input logic [2:0] s, input logic [7:0] m,
                      input logic ui, input logic [DW-1:0] v, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input string tag);
    logic [7:0]    ns;
    logic          ne, nar, nidx8;
    logic [DW-1:0] d;
    op = o; fsel = s; mask = m; uidx = ui; val = v; ca = a; cb = b;
    ns = m_st; ne = m_emu;
    nar = ui ? (m_emu | m_st[4]) : (m_emu | m_st[5]);
    case (o)
      4'd1: ns[s] = 1'b1;
      4'd2: ns[s] = 1'b0;
      4'd3: ns = m_st & ~m;
      4'd4: ns = m_st | m;
      4'd5: begin
        ns[0] = m_emu; ne = m_st[0];
        if (ne && !m_emu) begin ns[5] = 1'b1; ns[4] = 1'b1; end
      end
      4'd6: ns = m;
      4'd7: begin
        ns[7] = nar ? v[7] : v[15];
        ns[1] = nar ? (v[7:0] == 8'h00) : (v == 16'h0000);
      end
      4'd8: begin
        if (nar) begin
          d = {8'h00, a[7:0] - b[7:0]};
          ns[7] = d[7]; ns[1] = (d[7:0] == 8'h00); ns[0] = (a[7:0] >= b[7:0]);
        end else begin
          d = a - b;
          ns[7] = d[15]; ns[1] = (d == 16'h0000); ns[0] = (a >= b);
        end
      end
      default: ;
    endcase
    if (ne) ns[5] = 1'b1;
    nidx8 = ne | ns[4];
    m_st = ns; m_emu = ne;
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag, nidx8 & ~m_idx8);
    m_idx8 = nidx8;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pts [9];
    logic [DW-1:0] lv  [8];
    pts = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFF};
    lv  = '{16'h0000, 16'h0080, 16'h8000, 16'h0100, 16'h00FF, 16'h7FFF, 16'hFFFF, 16'h8001};
    m_st = 8'h30; m_emu = 1'b1; m_idx8 = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_outputs("R1 reset", 1'b0);

    // R8/R5: pulls in emulation; bit 4 is free, bit 5 held
    for (int v = 0; v < 256; v++) step(4'd6, 3'd0, 8'(v), 1'b0, '0, '0, '0, "R8 R5 pull emu");
    // R4: leave emulation (carry 0 -> emu 0, carry 1)
    step(4'd6, 3'd0, 8'h30, 1'b0, '0, '0, '0, "R8 pull");
    step(4'd5, 3'd0, 8'h00, 1'b0, '0, '0, '0, "R4 swap to native");
    // R8/R10/R9: native pulls across all size combinations
    for (int v = 0; v < 256; v++) step(4'd6, 3'd0, 8'(v ^ 8'h10), 1'b0, '0, '0, '0, "R8 R10 R9 pull native");
    // R2: single flag set/clear from two backgrounds
    for (int bg = 0; bg < 2; bg++) begin
      step(4'd6, 3'd0, bg ? 8'hAA : 8'h55, 1'b0, '0, '0, '0, "R8 pull");
      for (int i = 0; i < 8; i++) begin
        step(4'd1, 3'(i), 8'h00, 1'b0, '0, '0, '0, "R2 flag set");
        step(4'd2, 3'(i), 8'h00, 1'b0, '0, '0, '0, "R2 flag clear");
        step(4'd1, 3'(i), 8'h00, 1'b0, '0, '0, '0, "R2 R9 flag set again");
      end
    end
    // R3: masks against two patterns
    for (int k = 0; k < 256; k++) begin
      step(4'd6, 3'd0, 8'hA5, 1'b0, '0, '0, '0, "R8 pull");
      step(4'd4, 3'd0, 8'(k), 1'b0, '0, '0, '0, "R3 mask set");
      step(4'd6, 3'd0, 8'h5A, 1'b0, '0, '0, '0, "R8 pull");
      step(4'd3, 3'd0, 8'(k), 1'b0, '0, '0, '0, "R3 mask clear");
    end
    // R6/R7: every M/X combination, both width sources
    for (int sz = 0; sz < 4; sz++) begin
      for (int u = 0; u < 2; u++) begin
        for (int j = 0; j < 8; j++) begin
          step(4'd6, 3'd0, {2'b01, sz[1:0], 4'b0101}, 1'b0, '0, '0, '0, "R8 pull");
          step(4'd7, 3'd0, 8'h00, u[0], lv[j], '0, '0, "R6 load nz");
        end
        for (int x = 0; x < 9; x++)
          for (int y = 0; y < 9; y++) begin
            step(4'd6, 3'd0, {2'b01, sz[1:0], 4'b1010}, 1'b0, '0, '0, '0, "R8 pull");
            step(4'd8, 3'd0, 8'h00, u[0], '0, pts[x], pts[y], "R7 compare");
          end
      end
    end
    // R10: unused codes and no-op leave state alone
    step(4'd6, 3'd0, 8'hC3, 1'b0, '0, '0, '0, "R8 pull");
    for (int c = 9; c < 16; c++) step(4'(c), 3'd5, 8'hFF, 1'b1, 16'h0000, 16'h1, 16'h2, "R10 unused op");
    step(4'd0, 3'd2, 8'hFF, 1'b0, 16'h0000, '0, '0, "R10 no-op");
    // R4/R5/R9: enter emulation with 16-bit index and carry 1
    step(4'd6, 3'd0, 8'h01, 1'b0, '0, '0, '0, "R8 pull");
    step(4'd5, 3'd0, 8'h00, 1'b0, '0, '0, '0, "R4 R5 R9 swap to emu");
    step(4'd2, 3'd4, 8'h00, 1'b0, '0, '0, '0, "R5 clear break");
    step(4'd2, 3'd5, 8'h00, 1'b0, '0, '0, '0, "R5 M held");
    step(4'd3, 3'd0, 8'hFF, 1'b0, '0, '0, '0, "R5 R3 mask clear emu");
    step(4'd7, 3'd0, 8'h00, 1'b1, 16'h0100, '0, '0, "R6 R5 load emu narrow");
    step(4'd8, 3'd0, 8'h00, 1'b1, '0, 16'h0100, 16'h0001, "R7 R5 compare emu narrow");
    step(4'd5, 3'd0, 8'h00, 1'b0, '0, '0, '0, "R4 swap back");

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule